// File: doc/BRIEF.md
# Card Session Activation Sequencer

This block brings a contact card's supply, data lines, clock and reset up in a fixed timed order, and takes them down again in the reverse order. A host asks for a session by pulling an active-low request line. The host also drives a reset line, and its level at the start of the session chooses how the card clock starts. All step timing is counted in half units of T, where T is a parameterised number of periods of an internal oscillator. That oscillator runs at a fast rate from the start of activation until the card supply is reported discharged. The oscillator is modelled as a divider of the system clock.

A power-on hold-off keeps the interface idle after the supply monitor clears, and a card-presence debounce filters insertions. Once a session is open, any fault flag or a card removal aborts it at once through the same deactivation sequence. The abort drives the active-low host interrupt low. The interrupt stays latched low until the host withdraws the request and the sequencer is idle again. Analog supply generation, ramp shaping and level shifting are outside the block; they appear only as enable outputs.

Top module: `card_session_top`

## Requirements
- R1: No activation starts until POR_CYCLES consecutive system clock cycles have passed with fault bit 1 (supply undervoltage) low; a request held low during the hold-off starts activation on the cycle after the hold-off ends.
- R2: With the hold-off done, the debounced card present and no latched fault, a low session request raises `vcc_en` and `osc_fast` one clock later.
- R3: `vcc_ready` rises 3 half-T units after `vcc_en` rises.
- R4: `io_en` rises 8 half-T units after `vcc_en` rises; if `host_rst` was low when the session started, `cclk_en` rises at that same point.
- R5: If `host_rst` was high when the session started, `cclk_en` rises one clock after `host_rst` is seen low at or after 8 half-T units; a low level before 8 half-T units has no effect; at 14 half-T units the clock is enabled regardless.
- R6: `card_rst` stays low until 14 half-T units after `vcc_en` rises, and from then on it follows `host_rst` combinationally.
- R7: Deactivation drops `card_rst` at once, then `cclk_en` after 1, `io_en` after 2 and `vcc_en` with `vcc_ready` after 3 half-T units; `osc_fast` falls one clock after `vcc_discharged` is seen high.
- R8: Outside a session `irq_n` reflects the debounced presence: it rises only after DEB_CYCLES consecutive cycles of `card_pres` high and falls on the first clock with `card_pres` low.
- R9: Any fault bit high during a session (activating or active) starts deactivation and drives `irq_n` low on the next clock; `irq_n` stays low, and no new session starts, until the request is high with the sequencer idle.
- R10: Card removal during a session starts deactivation on the first clock that sees `card_pres` low, with no debounce.
- R11: Fault bits 0 (overcurrent) and 2 (overtemperature) have no effect outside a session: `irq_n` and `vcc_en` are unchanged.
- R12: One half-T unit lasts FAST_DIV × OSC_PER_T / 2 system clock cycles, counted from the cycle a sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| session_req_n | input | 1 | Host session request, active low |
| host_rst | input | 1 | Host reset request, copied to the card after activation |
| card_pres | input | 1 | Card presence, high when a card is present |
| fault_flags | input | 4 | Bit 0 overcurrent, bit 1 supply undervoltage, bit 2 overtemperature, bit 3 generator out of range |
| vcc_discharged | input | 1 | Card supply has fallen to its inactive level |
| vcc_en | output | 1 | Card supply generator enable |
| vcc_ready | output | 1 | Card supply ramp finished |
| io_en | output | 1 | Data line enable |
| cclk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset line |
| irq_n | output | 1 | Host interrupt, active low |
| osc_fast | output | 1 | Internal oscillator fast-rate select |

## Verification
A step counter that slips by one, or a half-T timer that does not restart at the start of a sequence, moves an enable edge by a whole half-T unit. That error shows up on the very first enable after `vcc_en` rises, so the bench samples each enable one cycle before and exactly at its expected edge. A wrong clock-start mode or a lost fault latch shows up within one clock as `cclk_en` or `irq_n` taking the other value. A deactivation that leaves a state too early shows on `osc_fast` before `vcc_discharged` is raised.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_ON,
    S_DEACT,
    S_DISCH
  } seq_state_t;

  localparam int STEP_W = 4;

  // activation steps, in half-T units after supply enable
  localparam logic [STEP_W-1:0] ST_READY = 4'd3;
  localparam logic [STEP_W-1:0] ST_IO    = 4'd8;
  localparam logic [STEP_W-1:0] ST_RST   = 4'd14;

  // deactivation steps, in half-T units after reset drop
  localparam logic [STEP_W-1:0] DS_CLK = 4'd1;
  localparam logic [STEP_W-1:0] DS_IO  = 4'd2;
  localparam logic [STEP_W-1:0] DS_SUP = 4'd3;

  localparam int FLT_OVC  = 0;
  localparam int FLT_UV   = 1;
  localparam int FLT_TEMP = 2;
  localparam int FLT_GEN  = 3;
  localparam int FLT_W    = 4;

  // system clock cycles in one half-T unit
  function automatic int half_t_cycles(input logic fast, input int fdiv,
                                       input int sdiv, input int osc_per_t);
    return (fast ? fdiv : sdiv) * (osc_per_t / 2);
  endfunction

endpackage

// File: rtl/cs_stable_filter.sv
module cs_stable_filter #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!din) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!q) begin
      if (cnt == CW'(N - 1)) q <= 1'b1;
      else                   cnt <= cnt + 1'b1;
    end
  end

  // R8 / R1: the filtered level only rises while the raw level is high
  assert_rise_after_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(din));

endmodule

// File: rtl/cs_halft_timer.sv
module cs_halft_timer
  import card_seq_pkg::*;
#(
  parameter int FAST_DIV  = 8,
  parameter int SLOW_DIV  = 64,
  parameter int OSC_PER_T = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic restart,
  output logic tick
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int MAX_LEN = MAX_DIV * (OSC_PER_T / 2);
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len;

  assign len  = CW'(half_t_cycles(fast, FAST_DIV, SLOW_DIV, OSC_PER_T));
  assign tick = (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R12: consecutive half-T ticks never come back to back
  assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && fast) |=> !tick);

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import card_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             session_n,
  input  logic             host_rst,
  input  logic             pres_raw,
  input  logic             pres_db,
  input  logic             por_ok,
  input  logic [FLT_W-1:0] faults,
  input  logic             discharged,
  input  logic             tick,
  output logic             restart,
  output logic             sup_en,
  output logic             sup_ready,
  output logic             io_en,
  output logic             clk_en,
  output logic             card_rst,
  output logic             irq_n,
  output logic             osc_fast
);
  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_nx;
  logic              wait_mode;
  logic              flt_latch;

  // named internal events
  logic in_session, abort_cause, deact_go, start_go;

  assign in_session  = (state == S_ACT) || (state == S_ON);
  assign abort_cause = in_session && ((|faults) || !pres_raw);
  assign deact_go    = in_session && (session_n || abort_cause);
  assign start_go    = (state == S_IDLE) && por_ok && !session_n && pres_db && !flt_latch;
  assign restart     = start_go || deact_go;
  assign step_nx     = step + 1'b1;

  assign osc_fast = (state != S_IDLE);
  assign card_rst = (state == S_ON) && host_rst;
  assign irq_n    = !flt_latch && pres_db;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      step      <= '0;
      wait_mode <= 1'b0;
      flt_latch <= 1'b0;
      sup_en    <= 1'b0;
      sup_ready <= 1'b0;
      io_en     <= 1'b0;
      clk_en    <= 1'b0;
    end else begin
      if (abort_cause)                         flt_latch <= 1'b1;
      else if (state == S_IDLE && session_n)   flt_latch <= 1'b0;

      case (state)
        S_IDLE: begin
          if (start_go) begin
            state     <= S_ACT;
            step      <= '0;
            sup_en    <= 1'b1;
            wait_mode <= host_rst;
          end
        end
        S_ACT: begin
          if (deact_go) begin
            state <= S_DEACT;
            step  <= '0;
          end else begin
            if (wait_mode && !host_rst && step >= ST_IO) clk_en <= 1'b1;
            if (tick) begin
              step <= step_nx;
              if (step_nx == ST_READY) sup_ready <= 1'b1;
              if (step_nx == ST_IO) begin
                io_en <= 1'b1;
                if (!wait_mode) clk_en <= 1'b1;
              end
              if (step_nx == ST_RST) begin
                clk_en <= 1'b1;
                state  <= S_ON;
              end
            end
          end
        end
        S_ON: begin
          if (deact_go) begin
            state <= S_DEACT;
            step  <= '0;
          end
        end
        S_DEACT: begin
          if (tick) begin
            step <= step_nx;
            if (step_nx == DS_CLK) clk_en <= 1'b0;
            if (step_nx == DS_IO)  io_en  <= 1'b0;
            if (step_nx == DS_SUP) begin
              sup_en    <= 1'b0;
              sup_ready <= 1'b0;
              state     <= S_DISCH;
            end
          end
        end
        S_DISCH: begin
          if (discharged) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: supply only comes up once the hold-off has ended
  assert_sup_after_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_en) |-> $past(por_ok));

  // R2: the oscillator is already fast when the supply comes up
  assert_fast_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_en) |-> osc_fast);

  // R6: reset is released only with clock, data lines and supply on
  assert_rst_needs_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (clk_en && io_en && sup_en));

  // R7: data lines never outlive the supply
  assert_io_under_sup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> sup_en);

  // R7: supply drops last
  assert_sup_off_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_en) |-> (!io_en && !clk_en));

  // R9: a fault inside a session pulls the interrupt low next cycle
  assert_fault_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_session && (|faults)) |=> !irq_n);

endmodule

// File: rtl/card_session_top.sv
module card_session_top
  import card_seq_pkg::*;
#(
  parameter int POR_CYCLES = 11000,
  parameter int DEB_CYCLES = 400000,
  parameter int FAST_DIV   = 8,
  parameter int SLOW_DIV   = 64,
  parameter int OSC_PER_T  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       session_req_n,
  input  logic       host_rst,
  input  logic       card_pres,
  input  logic [3:0] fault_flags,
  input  logic       vcc_discharged,
  output logic       vcc_en,
  output logic       vcc_ready,
  output logic       io_en,
  output logic       cclk_en,
  output logic       card_rst,
  output logic       irq_n,
  output logic       osc_fast
);
  logic por_ok, pres_db, tick, restart;

  cs_stable_filter #(.N(POR_CYCLES)) u_por (
    .clk(clk), .rst_n(rst_n), .din(!fault_flags[FLT_UV]), .q(por_ok));

  cs_stable_filter #(.N(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .din(card_pres), .q(pres_db));

  cs_halft_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .OSC_PER_T(OSC_PER_T)) u_tmr (
    .clk(clk), .rst_n(rst_n), .fast(osc_fast), .restart(restart), .tick(tick));

  cs_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .session_n(session_req_n), .host_rst(host_rst),
    .pres_raw(card_pres), .pres_db(pres_db), .por_ok(por_ok), .faults(fault_flags),
    .discharged(vcc_discharged), .tick(tick), .restart(restart),
    .sup_en(vcc_en), .sup_ready(vcc_ready), .io_en(io_en), .clk_en(cclk_en),
    .card_rst(card_rst), .irq_n(irq_n), .osc_fast(osc_fast));

endmodule

// File: tb/card_session_top_tb.sv
`timescale 1ns/1ps
module card_session_top_tb;
  localparam int POR = 100;
  localparam int DEB = 30;
  localparam int FD  = 2;
  localparam int OPT = 64;
  localparam int L   = FD * OPT / 2;   // R12: half-T in system cycles

  // activation checkpoints: offset after supply enable, {vcc,rdy,io,clk,rst}
  localparam int NV = 7;
  localparam int VOFS [NV] = '{0, 3*L-1, 3*L, 8*L-1, 8*L, 14*L-1, 14*L};
  localparam logic [4:0] VEXP [NV] = '{5'b10000, 5'b10000, 5'b11000, 5'b11000,
                                       5'b11110, 5'b11110, 5'b11110};

  logic clk = 0, rst_n = 0;
  logic session_req_n = 1, host_rst = 0, card_pres = 0, vcc_discharged = 0;
  logic [3:0] fault_flags = '0;
  logic vcc_en, vcc_ready, io_en, cclk_en, card_rst, irq_n, osc_fast;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_session_top #(.POR_CYCLES(POR), .DEB_CYCLES(DEB), .FAST_DIV(FD),
                     .SLOW_DIV(4), .OSC_PER_T(OPT)) u_dut (
    .clk(clk), .rst_n(rst_n), .session_req_n(session_req_n), .host_rst(host_rst),
    .card_pres(card_pres), .fault_flags(fault_flags), .vcc_discharged(vcc_discharged),
    .vcc_en(vcc_en), .vcc_ready(vcc_ready), .io_en(io_en), .cclk_en(cclk_en),
    .card_rst(card_rst), .irq_n(irq_n), .osc_fast(osc_fast));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int cur;
    adv(3);
    chk("R1 reset outputs", 8'({vcc_en, vcc_ready, io_en, cclk_en, card_rst, osc_fast}), 8'h00);
    chk("R8 reset irq no card", 8'(irq_n), 8'h0);
    rst_n = 1;

    // R8 debounce of an insertion
    adv(1); card_pres = 1;
    adv(1); adv(DEB-2);
    chk("R8 irq before debounce", 8'(irq_n), 8'h0);
    adv(1);
    chk("R8 irq after debounce", 8'(irq_n), 8'h1);

    // R1 hold-off restarted by undervoltage, request held low meanwhile
    adv(1); fault_flags[1] = 1;
    adv(1); fault_flags[1] = 0; session_req_n = 0;
    adv(1); adv(POR-1);
    chk("R1 no supply during hold-off", 8'(vcc_en), 8'h0);
    adv(1);
    chk("R2 supply and fast osc", 8'({vcc_en, osc_fast}), 8'h3);

    // R3 R4 R12 activation table, host reset low at start
    cur = 0;
    for (int i = 0; i < NV; i++) begin
      adv(VOFS[i] - cur);
      cur = VOFS[i];
      chk($sformatf("R3 R4 R12 vec %0d", i),
          8'({vcc_en, vcc_ready, io_en, cclk_en, card_rst}), 8'(VEXP[i]));
    end

    // R6 reset follows host after release
    host_rst = 1;
    adv(1);
    chk("R6 card_rst follows host", 8'(card_rst), 8'h1);

    // R7 deactivation order
    session_req_n = 1;
    adv(1);
    chk("R7 rst drops first", 8'({card_rst, cclk_en}), 8'h1);
    adv(L-1); chk("R7 clk still on", 8'(cclk_en), 8'h1);
    adv(1);   chk("R7 clk off", 8'({cclk_en, io_en}), 8'h1);
    adv(L-1); chk("R7 io still on", 8'(io_en), 8'h1);
    adv(1);   chk("R7 io off", 8'({io_en, vcc_en}), 8'h1);
    adv(L-1); chk("R7 vcc still on", 8'(vcc_en), 8'h1);
    adv(1);   chk("R7 vcc off", 8'({vcc_en, vcc_ready}), 8'h0);
    adv(5);   chk("R7 osc fast until discharged", 8'(osc_fast), 8'h1);
    vcc_discharged = 1;
    adv(1);   chk("R7 osc slow", 8'(osc_fast), 8'h0);
    chk("R8 irq present after session", 8'(irq_n), 8'h1);
    vcc_discharged = 0;

    // R5 host-timed clock start, host reset high at start
    host_rst = 1; session_req_n = 0;
    adv(1); adv(4*L);
    host_rst = 0;
    adv(3); host_rst = 1;
    adv(4*L);
    chk("R5 early low ignored", 8'({io_en, cclk_en}), 8'h2);
    adv(L-3); host_rst = 0;
    adv(1);
    chk("R5 clock on host low", 8'(cclk_en), 8'h1);

    // R9 fault aborts and latches
    fault_flags[0] = 1;
    adv(1);
    chk("R9 irq low on fault", 8'({irq_n, vcc_en}), 8'h1);
    fault_flags[0] = 0;
    adv(3*L+2);
    vcc_discharged = 1;
    adv(3);
    chk("R9 held idle while latched", 8'({vcc_en, osc_fast, irq_n}), 8'h0);
    vcc_discharged = 0; session_req_n = 1;
    adv(1);
    chk("R9 latch clears", 8'(irq_n), 8'h1);

    // R5 forced clock at 14 half-T with host reset held high
    host_rst = 1; session_req_n = 0;
    adv(1); adv(14*L-1);
    chk("R5 clock off before t5", 8'(cclk_en), 8'h0);
    adv(1);
    chk("R5 R6 clock and reset at t5", 8'({cclk_en, card_rst}), 8'h3);

    // R10 removal aborts at once
    card_pres = 0;
    adv(1);
    chk("R10 removal abort", 8'({irq_n, card_rst, vcc_en}), 8'h1);
    adv(L);
    chk("R10 clock off after removal", 8'(cclk_en), 8'h0);
    session_req_n = 1;
    adv(3*L);
    vcc_discharged = 1;
    adv(2);
    vcc_discharged = 0;
    chk("R10 supply off", 8'(vcc_en), 8'h0);

    // R11 faults ignored outside a session
    card_pres = 1;
    adv(DEB+2);
    fault_flags = 4'b0101;
    adv(10);
    chk("R11 faults ignored idle", 8'({irq_n, vcc_en}), 8'h2);
    fault_flags = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule